// File: doc/BRIEF.md
# Packed Unsigned Halfword Minimum Slice

This execution slice accepts two packed vectors of 16-bit unsigned lanes and writes the smaller lane of each pair into a 256-bit destination. It has three operating forms. The first is a 128-bit form that overwrites its first operand and leaves the top half of the destination untouched. The second is a 128-bit form with three operands, which clears the top half. The third is a full-width form that computes every lane. A fourth form code is reserved. When it is used, the slice raises an illegal flag and returns the old destination value unchanged.

The caller presents three inputs: the previous destination register value, a first source and a second source. The second source may have been read from a register or from memory, and the slice treats it only as data. One cycle after `in_valid`, the slice registers the result and a valid strobe. Each lane is independent of the others: there is no carry between lanes, no saturation and no flag output.

Top module: `pminw_slice`

## Requirements
- R1: Each result lane i equals the unsigned minimum of first-source lane i and second-source lane i. Lane i occupies bits 16*i+15 : 16*i.
- R2: If the two lanes are equal, or the first lane is not strictly smaller, the result lane takes the second-source value.
- R3: With form 2'b00 (overwrite-128), the first source is the old destination. The result computes lanes 0..7 from `dst_old` and `src_b`. Bits 255:128 equal `dst_old[255:128]`. The `src_a` input has no effect.
- R4: With form 2'b01 (three-operand 128), lanes 0..7 are computed from `src_a` and `src_b`, and bits 255:128 of the result are zero.
- R5: With form 2'b10 (full width), all sixteen lanes are computed from `src_a` and `src_b`.
- R6: With form 2'b11 (reserved), the result equals `dst_old` and `out_illegal` is 1. For every legal form, `out_illegal` is 0.
- R7: `out_valid` is `in_valid` delayed by one clock. The result and `out_illegal` are registered in the same cycle as `out_valid`.
- R8: A synchronous active-high reset clears `out_valid`, `out_illegal` and the result.
- R9: Lanes are independent. The value 0x0000 compared with 0xFFFF yields 0x0000 in either operand order, and a lane's result does not change with the values in the other lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands presented this cycle |
| form_sel | input | 2 | 00 overwrite-128, 01 three-operand 128, 10 full width, 11 reserved |
| dst_old | input | 256 | Previous destination register value |
| src_a | input | 256 | First source (three-operand forms) |
| src_b | input | 256 | Second source (register or memory data) |
| out_valid | output | 1 | Result valid |
| out_illegal | output | 1 | Reserved form was used |
| result | output | 256 | Value written to the destination |

## Verification
The bench builds the slice with its default parameters: 16-bit lanes, a 256-bit vector and a 128-bit narrow half. These values bring all sixteen lanes and the boundary between the narrow and full halves within reach of every form. The reference model computes each lane with integer comparisons and applies the rule for the upper half of each form separately. The stimulus covers random operands, lanes that are equal by construction, 0x0000 against 0xFFFF in both orders, all four form codes, and cycles where the valid strobe is low.

// File: rtl/pminw_pkg.sv
package pminw_pkg;
    localparam int LANE_W   = 16;
    localparam int VEC_W    = 256;
    localparam int NARROW_W = 128;
    localparam int N_LANES  = VEC_W / LANE_W;
    localparam int N_NARROW = NARROW_W / LANE_W;

    typedef enum logic [1:0] {
        FORM_OVR128 = 2'b00,
        FORM_TRI128 = 2'b01,
        FORM_FULL   = 2'b10,
        FORM_RSVD   = 2'b11
    } form_e;

    typedef struct packed {
        logic             vld;
        logic             ill;
        logic [VEC_W-1:0] res;
    } out_reg_t;
endpackage

// File: rtl/pminw_lane.sv
module pminw_lane #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    always_comb begin
        if (a < b) y = a;
        else       y = b;
    end
endmodule

// File: rtl/pminw_array.sv
module pminw_array #(
    parameter int LANE_W  = 16,
    parameter int N_LANES = 16,
    localparam int VW     = LANE_W * N_LANES
) (
    input  logic [VW-1:0] a,
    input  logic [VW-1:0] b,
    output logic [VW-1:0] y
);
    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        pminw_lane #(.W(LANE_W)) u_lane (
            .a(a[i*LANE_W +: LANE_W]),
            .b(b[i*LANE_W +: LANE_W]),
            .y(y[i*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/pminw_merge.sv
module pminw_merge
    import pminw_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int NW = NARROW_W
) (
    input  logic [1:0]    form,
    input  logic [VW-1:0] dst_old,
    input  logic [VW-1:0] mins,
    output logic [VW-1:0] merged,
    output logic          illegal
);
    always_comb begin
        merged  = dst_old;
        illegal = 1'b0;
        unique case (form)
            FORM_OVR128: merged = {dst_old[VW-1:NW], mins[NW-1:0]};
            FORM_TRI128: merged = {{(VW-NW){1'b0}}, mins[NW-1:0]};
            FORM_FULL:   merged = mins;
            default: begin
                merged  = dst_old;
                illegal = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pminw_slice.sv
module pminw_slice
    import pminw_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int VW = VEC_W,
    parameter int NW = NARROW_W,
    localparam int NL = VW / LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    form_sel,
    input  logic [VW-1:0] dst_old,
    input  logic [VW-1:0] src_a,
    input  logic [VW-1:0] src_b,
    output logic          out_valid,
    output logic          out_illegal,
    output logic [VW-1:0] result
);
    logic [VW-1:0] first_src;
    logic [VW-1:0] mins;
    logic [VW-1:0] merged;
    logic          illegal;

    typedef struct packed {
        logic          vld;
        logic          ill;
        logic [VW-1:0] res;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        if (form_sel == FORM_OVR128) first_src = dst_old;
        else                         first_src = src_a;
    end

    pminw_array #(.LANE_W(LW), .N_LANES(NL)) u_arr (
        .a(first_src), .b(src_b), .y(mins)
    );

    pminw_merge #(.VW(VW), .NW(NW)) u_merge (
        .form(form_sel), .dst_old(dst_old), .mins(mins),
        .merged(merged), .illegal(illegal)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.ill = illegal;
            st_d.res = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid   = st_q.vld;
    assign out_illegal = st_q.ill;
    assign result      = st_q.res;
endmodule

// File: rtl/pminw_slice_chk.sv
module pminw_slice_chk #(
    parameter int VW = 256,
    parameter int NW = 128
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [1:0]    form_sel,
    input logic [VW-1:0] dst_old,
    input logic          out_valid,
    input logic          out_illegal,
    input logic [VW-1:0] result
);
    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R7
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R4
    tri_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 2'b01) |=> (result[VW-1:NW] == '0));
    // R3
    ovr_upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 2'b00) |=> (result[VW-1:NW] == $past(dst_old[VW-1:NW])));
    // R6
    rsvd_flag_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_illegal == ($past(form_sel) == 2'b11)));
    // R6
    rsvd_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && form_sel == 2'b11) |=> (result == $past(dst_old)));
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal && result == '0));
endmodule

bind pminw_slice pminw_slice_chk #(.VW(VW), .NW(NW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .form_sel(form_sel),
    .dst_old(dst_old), .out_valid(out_valid), .out_illegal(out_illegal),
    .result(result)
);

// File: tb/tb_pminw_slice.sv
module tb_pminw_slice;
    logic         clk = 0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   form_sel;
    logic [255:0] dst_old, src_a, src_b;
    logic         out_valid, out_illegal;
    logic [255:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #10 clk = ~clk;

    pminw_slice dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .form_sel(form_sel),
        .dst_old(dst_old), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .out_illegal(out_illegal), .result(result)
    );

    function automatic logic [255:0] model(input logic [1:0] f,
            input logic [255:0] d, input logic [255:0] a, input logic [255:0] b);
        logic [255:0] r;
        int x, y;
        r = d;
        if (f == 2'b11) return d;
        for (int i = 0; i < 16; i++) begin
            x = (f == 2'b00) ? int'(d[i*16 +: 16]) : int'(a[i*16 +: 16]);
            y = int'(b[i*16 +: 16]);
            if (i < 8 || f == 2'b10) r[i*16 +: 16] = 16'((x < y) ? x : y);
            else if (f == 2'b01) r[i*16 +: 16] = 16'h0;
        end
        return r;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Drive one operation; check one cycle later, sampled on the falling edge.
    task automatic op(input string req, input logic [1:0] f,
            input logic [255:0] d, input logic [255:0] a, input logic [255:0] b);
        logic [255:0] e;
        e = model(f, d, a, b);
        @(negedge clk);
        in_valid = 1; form_sel = f; dst_old = d; src_a = a; src_b = b;
        @(negedge clk);
        in_valid = 0;
        chk(req, result, e);
        chk({req, "/R6 illegal"}, {255'b0, out_illegal}, {255'b0, f == 2'b11});
        chk({req, "/R7 valid"}, {255'b0, out_valid}, 256'd1);
    endtask

    initial begin
        logic [255:0] d, a, b, e;
        rst = 1; in_valid = 0; form_sel = 0; dst_old = 0; src_a = 0; src_b = 0;
        repeat (3) @(negedge clk);
        // R8
        chk("R8 reset result", result, '0);
        chk("R8 reset flags", {254'b0, out_valid, out_illegal}, '0);
        rst = 0;

        // R9: 0 vs FFFF, both orders, all lanes
        op("R9 zero-first", 2'b10, '0, '0, {256{1'b1}});
        op("R9 zero-second", 2'b10, '0, {256{1'b1}}, '0);
        // R2: equal lanes
        a = rnd256();
        op("R2 equal", 2'b10, '0, a, a);
        op("R2 equal narrow", 2'b01, rnd256(), a, a);
        // R3: src_a ignored in overwrite form
        d = rnd256(); b = rnd256();
        op("R3 ovr", 2'b00, d, rnd256(), b);
        op("R3 ovr src_a ignored", 2'b00, d, {256{1'b1}}, b);
        // R4
        op("R4 tri", 2'b01, {256{1'b1}}, rnd256(), rnd256());
        // R6
        op("R6 reserved", 2'b11, rnd256(), rnd256(), rnd256());
        // R9: mixed-extreme lanes alternate
        op("R9 alt lanes", 2'b10, '0, {16{16'h0000, 16'hFFFF}}, {16{16'hFFFF, 16'h0000}});
        // R1/R5 random across all forms
        for (int k = 0; k < 200; k++) begin
            op((k % 4 == 2) ? "R5 full rand" : "R1 rand", 2'(k % 4), rnd256(), rnd256(), rnd256());
        end
        // R7: idle cycle drops valid
        @(negedge clk);
        chk("R7 idle", {255'b0, out_valid}, '0);
        // R7: back-to-back operations
        d = rnd256(); a = rnd256(); b = rnd256();
        e = model(2'b10, d, a, b);
        @(negedge clk);
        in_valid = 1; form_sel = 2'b10; dst_old = d; src_a = a; src_b = b;
        @(negedge clk);
        chk("R7 b2b first", result, e);
        e = model(2'b01, d, b, a);
        form_sel = 2'b01; src_a = b; src_b = a;
        @(negedge clk);
        in_valid = 0;
        chk("R7 b2b second", result, e);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_tests++; n_fail++;
                $display("FAIL watchdog act=timeout exp=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule